// File: doc/BRIEF.md
# Byte-Programmed Up/Down Counter Channel

This block is a single up/down counting channel with three 24-bit registers behind two 8-bit ports: the count itself, a preset that doubles as the ceiling, and an output latch that software reads. A data port moves values one byte at a time through a shared byte pointer. A control port accepts command and configuration bytes, and it always presents a status flag byte. Count pulses and their direction come from an external edge decoder. The block returns the selected input mode to that decoder and also drives the filter prescaler value and the index configuration.

The count can never be written directly. Software places a value in the preset register and then issues a transfer command, or it arms the index input so that an index pulse copies the preset into the count. The carry and borrow flags are toggle flags. Their exclusive-or acts as a 25th count bit, which lets software extend the range to 0x1FFFFFF.

Top module: `byte_counter_channel`

## Requirements
- R1: The target of a control write is chosen by bits [7:5]: 000 is the command group, 001 the mode register, 010 the I/O register and 011 the index register. Codes 100 to 111 change nothing. Mode register bits [4:3] appear on `input_mode`, and index register bits [1:0] appear on `index_cfg`.
- R2: The byte pointer has three states. A data write stores `wdata` into the preset byte the pointer selects. `rdata` shows the output latch byte the pointer selects, least significant byte first. Each data access advances the pointer, and it wraps from the third byte back to the first. Command bit 0 (0x01) returns the pointer to the first byte.
- R3: Data writes never change the count. Command 0x08 copies the preset into the count.
- R4: Command 0x10 copies the count into the output latch. At all other times the latch holds its value, so a read of several bytes is coherent.
- R5: A command byte that sets bit 0 together with a transfer code, such as 0x11, performs both actions.
- R6: Flag byte layout: bit 0 is borrow, bit 1 carry, bit 4 noise error and bit 5 direction (1 when the last counted pulse went up). All other bits read 0. All flags are 0 after reset.
- R7: Mode field value 0 (free running): counting up from 0xFFFFFF gives 0 and toggles carry. Counting down from 0 gives 0xFFFFFF and toggles borrow. Latch value plus (carry XOR borrow) at bit 24 forms a 25-bit count.
- R8: Mode field value 1 (range limit): the count stays at the preset when counting up and stays at 0 when counting down. The flags do not change.
- R9: Mode field value 2 (non-recycle): the count wraps as in R7, toggles the flag, and then ignores pulses until the next load (0x02, 0x08 or index).
- R10: Mode field value 3 (modulo-N): counting up from the preset gives 0 and toggles carry. Counting down from 0 gives the preset and toggles borrow.
- R11: Command 0x02 clears the count. Command 0x04 clears carry and borrow but not the error flag. Command 0x06 clears the error flag, which `noise_in` sets.
- R12: I/O register bit 0 enables counting; while it is 0, pulses are ignored. When I/O bit 1 is 0, an `index_pulse` loads the preset into the count. When it is 1, index pulses are ignored. After reset the value of that bit is 1.
- R13: Command 0x18 copies the low byte of the preset to `prescale`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| data_wr | input | 1 | Data byte write strobe |
| data_rd | input | 1 | Data byte read strobe (advances pointer) |
| wdata | input | 8 | Write byte for either port |
| rdata | output | 8 | Output latch byte at the pointer |
| flags | output | 8 | Status flag byte |
| cnt_step | input | 1 | One count pulse from the decoder |
| cnt_up | input | 1 | Direction of the pulse, 1 = up |
| index_pulse | input | 1 | Index event |
| noise_in | input | 1 | Noise detected on the count inputs |
| input_mode | output | 2 | Decoder mode: pulse/dir, x1, x2, x4 |
| ab_enable | output | 1 | Count inputs enabled |
| index_cfg | output | 2 | Index register contents |
| prescale | output | 8 | Filter prescaler value |

## Verification
The hardest states to reach are the boundaries of each count mode. These include the halt after a wrap in non-recycle mode and a ceiling that only exists in the preset register, and none of them can be set directly. The bench reaches each one by loading a starting count through the preset, reprogramming the preset as the ceiling, and then sweeping pulse bursts in both directions across every mode. Each result is checked against an arithmetic model that includes the 25th bit.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        TGT_CMD   = 3'b000,
        TGT_MODE  = 3'b001,
        TGT_IOCTL = 3'b010,
        TGT_INDEX = 3'b011
    } target_e;

    typedef enum logic [1:0] {
        CM_FREE    = 2'd0,
        CM_LIMIT   = 2'd1,
        CM_ONESHOT = 2'd2,
        CM_MODN    = 2'd3
    } cmode_e;

    typedef struct packed {
        logic ptr_clr;
        logic cnt_clr;
        logic flg_clr;
        logic err_clr;
        logic pre_to_cnt;
        logic cnt_to_lat;
        logic pre_to_psc;
        logic mode_wr;
        logic io_wr;
        logic idx_wr;
    } cmd_t;

    localparam int FLG_BORROW = 0;
    localparam int FLG_CARRY  = 1;
    localparam int FLG_ERROR  = 4;
    localparam int FLG_UP     = 5;

    function automatic cmd_t decode_ctrl(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c = '0;
        case (target_e'(b[7:5]))
            TGT_CMD: begin
                c.ptr_clr = b[0];
                case (b[4:3])
                    2'b00: begin
                        c.cnt_clr = (b[2:1] == 2'b01);
                        c.flg_clr = (b[2:1] == 2'b10);
                        c.err_clr = (b[2:1] == 2'b11);
                    end
                    2'b01:   c.pre_to_cnt = 1'b1;
                    2'b10:   c.cnt_to_lat = 1'b1;
                    default: c.pre_to_psc = 1'b1;
                endcase
            end
            TGT_MODE:  c.mode_wr = 1'b1;
            TGT_IOCTL: c.io_wr   = 1'b1;
            TGT_INDEX: c.idx_wr  = 1'b1;
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bcc_cmd_decode.sv
module bcc_cmd_decode
    import bcc_pkg::*;
(
    input  logic              wr,
    input  logic [BYTE_W-1:0] ctrl_byte,
    output cmd_t              cmd
);
    always_comb begin
        cmd = wr ? decode_ctrl(ctrl_byte) : '0;
    end
endmodule

// File: rtl/bcc_byte_ptr.sv
module bcc_byte_ptr #(
    parameter int NBYTES = 3,
    localparam int PW    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(NBYTES - 1);

    always_ff @(posedge clk) begin
        if (rst || clr)  ptr <= '0;
        else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ptr <= LAST);  // R2
    AST_PTR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr |=> ptr == '0);  // R2
endmodule

// File: rtl/bcc_count_core.sv
module bcc_count_core
    import bcc_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  cmode_e       mode,
    input  logic [W-1:0] ceil,
    input  logic         enable,
    input  logic         step,
    input  logic         up,
    input  logic         load_zero,
    input  logic         load_preset,
    input  logic         clr_flags,
    output logic [W-1:0] cnt_q,
    output logic         carry_q,
    output logic         borrow_q,
    output logic         up_q
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic         halted_q;
    logic         load;
    logic         go;
    logic         bounded;
    logic [W-1:0] top;

    assign load    = load_zero | load_preset;
    assign go      = enable & step & ~halted_q & ~load;
    assign bounded = (mode == CM_LIMIT) || (mode == CM_MODN);
    assign top     = bounded ? ceil : MAXV;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            carry_q  <= 1'b0;
            borrow_q <= 1'b0;
            halted_q <= 1'b0;
            up_q     <= 1'b0;
        end else begin
            if (load) begin
                cnt_q    <= load_preset ? ceil : '0;
                halted_q <= 1'b0;
            end else if (go) begin
                up_q <= up;
                if (up) begin
                    if (cnt_q == top) begin
                        case (mode)
                            CM_LIMIT: cnt_q <= cnt_q;
                            CM_ONESHOT: begin
                                cnt_q    <= '0;
                                carry_q  <= ~carry_q;
                                halted_q <= 1'b1;
                            end
                            default: begin
                                cnt_q   <= '0;
                                carry_q <= ~carry_q;
                            end
                        endcase
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        case (mode)
                            CM_LIMIT: cnt_q <= cnt_q;
                            CM_ONESHOT: begin
                                cnt_q    <= MAXV;
                                borrow_q <= ~borrow_q;
                                halted_q <= 1'b1;
                            end
                            CM_MODN: begin
                                cnt_q    <= ceil;
                                borrow_q <= ~borrow_q;
                            end
                            default: begin
                                cnt_q    <= MAXV;
                                borrow_q <= ~borrow_q;
                            end
                        endcase
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            end
            if (clr_flags) begin
                carry_q  <= 1'b0;
                borrow_q <= 1'b0;
            end
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(enable && step) && !load) |=> $stable(cnt_q));  // R12
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (halted_q && !load) |=> $stable(cnt_q));  // R9
    AST_CEIL_KEPT: assert property (@(posedge clk) disable iff (rst)
        (bounded && enable && step && !load && cnt_q <= ceil)
        |=> cnt_q <= $past(ceil));  // R10
    AST_ONE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (enable && step && !clr_flags)
        |=> $onehot0({carry_q != $past(carry_q), borrow_q != $past(borrow_q)}));  // R7
endmodule

// File: rtl/byte_counter_channel.sv
module byte_counter_channel
    import bcc_pkg::*;
#(
    parameter int CNT_W    = 24,
    localparam int NBYTES  = CNT_W / BYTE_W,
    localparam int PW      = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] flags,
    input  logic              cnt_step,
    input  logic              cnt_up,
    input  logic              index_pulse,
    input  logic              noise_in,
    output logic [1:0]        input_mode,
    output logic              ab_enable,
    output logic [1:0]        index_cfg,
    output logic [BYTE_W-1:0] prescale
);
    cmd_t              cmd;
    logic [PW-1:0]     ptr;
    logic [BYTE_W-1:0] preset_b [NBYTES];
    logic [CNT_W-1:0]  preset;
    logic [CNT_W-1:0]  latch_q;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        cmode_q;
    logic [1:0]        imode_q;
    logic              ab_en_q;
    logic              idx_load_n_q;
    logic [1:0]        idx_q;
    logic              err_q;
    logic              carry;
    logic              borrow;
    logic              upf;
    logic              idx_load;

    bcc_cmd_decode u_dec (
        .wr        (ctrl_wr),
        .ctrl_byte (wdata),
        .cmd       (cmd)
    );

    bcc_byte_ptr #(.NBYTES(NBYTES)) u_ptr (
        .clk (clk),
        .rst (rst),
        .clr (cmd.ptr_clr),
        .adv (data_wr | data_rd),
        .ptr (ptr)
    );

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)                                preset_b[i] <= '0;
            else if (data_wr && ptr == PW'(i))      preset_b[i] <= wdata;
        end
        assign preset[i*BYTE_W +: BYTE_W] = preset_b[i];
    end

    assign idx_load = index_pulse & ~idx_load_n_q;

    bcc_count_core #(.W(CNT_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .mode        (cmode_e'(cmode_q)),
        .ceil        (preset),
        .enable      (ab_en_q),
        .step        (cnt_step),
        .up          (cnt_up),
        .load_zero   (cmd.cnt_clr),
        .load_preset (cmd.pre_to_cnt | idx_load),
        .clr_flags   (cmd.flg_clr),
        .cnt_q       (cnt),
        .carry_q     (carry),
        .borrow_q    (borrow),
        .up_q        (upf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q      <= '0;
            cmode_q      <= '0;
            imode_q      <= '0;
            ab_en_q      <= 1'b0;
            idx_load_n_q <= 1'b1;
            idx_q        <= '0;
            err_q        <= 1'b0;
            prescale     <= '0;
        end else begin
            if (cmd.cnt_to_lat) latch_q  <= cnt;
            if (cmd.pre_to_psc) prescale <= preset[BYTE_W-1:0];
            if (cmd.mode_wr) begin
                cmode_q <= wdata[2:1];
                imode_q <= wdata[4:3];
            end
            if (cmd.io_wr) begin
                ab_en_q      <= wdata[0];
                idx_load_n_q <= wdata[1];
            end
            if (cmd.idx_wr) idx_q <= wdata[1:0];
            if (cmd.err_clr) err_q <= 1'b0;
            if (noise_in)    err_q <= 1'b1;
        end
    end

    assign rdata      = latch_q[ptr*BYTE_W +: BYTE_W];
    assign input_mode = imode_q;
    assign ab_enable  = ab_en_q;
    assign index_cfg  = idx_q;

    always_comb begin
        flags             = '0;
        flags[FLG_BORROW] = borrow;
        flags[FLG_CARRY]  = carry;
        flags[FLG_ERROR]  = err_q;
        flags[FLG_UP]     = upf;
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmd.cnt_to_lat |=> $stable(latch_q));  // R4
    AST_DATA_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !cmd.cnt_clr && !cmd.pre_to_cnt && !idx_load && !(ab_en_q && cnt_step))
        |=> $stable(cnt));  // R3
endmodule

// File: tb/byte_counter_channel_test.sv
`timescale 1ns/1ps
module byte_counter_channel_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_wr = 0, data_wr = 0, data_rd = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata, flags, prescale;
    logic       cnt_step = 0, cnt_up = 0, index_pulse = 0, noise_in = 0;
    logic [1:0] input_mode, index_cfg;
    logic       ab_enable;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    byte_counter_channel uut (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .data_wr(data_wr),
        .data_rd(data_rd), .wdata(wdata), .rdata(rdata), .flags(flags),
        .cnt_step(cnt_step), .cnt_up(cnt_up), .index_pulse(index_pulse),
        .noise_in(noise_in), .input_mode(input_mode), .ab_enable(ab_enable),
        .index_cfg(index_cfg), .prescale(prescale)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ctrl(input logic [7:0] b);
        @(negedge clk); ctrl_wr = 1; wdata = b;
        @(negedge clk); ctrl_wr = 0;
    endtask

    task automatic wdat(input logic [7:0] b);
        @(negedge clk); data_wr = 1; wdata = b;
        @(negedge clk); data_wr = 0;
    endtask

    task automatic rdat(output logic [7:0] b);
        @(negedge clk); b = rdata; data_rd = 1;
        @(negedge clk); data_rd = 0;
    endtask

    task automatic set_preset(input logic [23:0] v);
        ctrl(8'h01);
        wdat(v[7:0]); wdat(v[15:8]); wdat(v[23:16]);
    endtask

    task automatic load_cnt(input logic [23:0] v);
        set_preset(v);
        ctrl(8'h08);
    endtask

    task automatic read24(input bit latch_new, output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        ctrl(latch_new ? 8'h11 : 8'h01);
        rdat(b0); rdat(b1); rdat(b2);
        v = {b2, b1, b0};
    endtask

    task automatic pulses(input bit up, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_step = 1; cnt_up = up;
        end
        @(negedge clk); cnt_step = 0;
    endtask

    function automatic logic [25:0] ref_run(input int mode, input logic [23:0] ceil,
                                            input logic [23:0] start, input bit up, input int n);
        logic [23:0] v = start;
        logic [23:0] lim;
        bit c = 0, b = 0, h = 0;
        lim = (mode == 1 || mode == 3) ? ceil : 24'hFFFFFF;
        for (int i = 0; i < n; i++) begin
            if (!h) begin
                if (up) begin
                    if (v == lim) begin
                        if (mode != 1) begin v = 0; c = ~c; end
                        if (mode == 2) h = 1;
                    end else v = v + 1;
                end else begin
                    if (v == 0) begin
                        if (mode == 3) begin v = ceil; b = ~b; end
                        else if (mode != 1) begin v = 24'hFFFFFF; b = ~b; end
                        if (mode == 2) h = 1;
                    end else v = v - 1;
                end
            end
        end
        return {b, c, v};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %h expected %h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        logic [7:0]  b;
        logic [25:0] e;
        logic [23:0] st;
        logic [23:0] ceil;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // Reset state
        chk("R6 reset flags", flags, 8'h00);
        chk("R2 reset rdata", rdata, 8'h00);
        chk("R1 reset outputs", {input_mode, ab_enable, index_cfg, prescale}, 0);

        // R12: pulses ignored with inputs disabled
        ctrl(8'h42);
        pulses(1, 3);
        read24(1, v);
        chk("R12 disabled count", v, 24'h0);

        // R3: data writes do not reach the count
        set_preset(24'hABCDEF);
        read24(1, v);
        chk("R3 preset not counted", v, 24'h0);
        load_cnt(24'hABCDEF);
        ctrl(8'h11);
        rdat(b);
        chk("R2 LSB first", b, 8'hEF);
        rdat(b); rdat(b);
        chk("R2 MSB third", b, 8'hAB);
        rdat(b);
        chk("R2 pointer wraps", b, 8'hEF);
        ctrl(8'h01);
        rdat(b);
        chk("R2 pointer reset", b, 8'hEF);

        // R4: latch coherent until transfer
        ctrl(8'h43);
        pulses(1, 2);
        read24(0, v);
        chk("R4 latch held", v, 24'hABCDEF);
        chk("R6 up flag", flags[5], 1'b1);
        // R5: pointer reset and transfer in one byte, mid-read
        ctrl(8'h01);
        rdat(b);
        ctrl(8'h11);
        rdat(b);
        chk("R5 combined 0x11", b, 8'hF1);
        pulses(0, 1);
        chk("R6 down flag", flags[5], 1'b0);

        // R7: overflow toggles carry, 25th bit
        ctrl(8'h20);
        load_cnt(24'hFFFFFE);
        ctrl(8'h04);
        pulses(1, 3);
        read24(1, v);
        chk("R7 carry flag", flags[1:0], 2'b10);
        chk("R7 25-bit value", {flags[1] ^ flags[0], v}, 25'h1000001);
        pulses(0, 2);
        read24(1, v);
        chk("R7 borrow back", {flags[1] ^ flags[0], v}, 25'h0FFFFFF);

        // R11: flag clearing and error flag
        @(negedge clk); noise_in = 1;
        @(negedge clk); noise_in = 0;
        chk("R11 error set", flags[4], 1'b1);
        ctrl(8'h04);
        chk("R11 0x04 keeps error", flags & 8'h13, 8'h10);
        ctrl(8'h06);
        chk("R11 0x06 clears error", flags[4], 1'b0);
        ctrl(8'h02);
        read24(1, v);
        chk("R11 clear counter", v, 24'h0);

        // R12: index load
        ctrl(8'h41);
        set_preset(24'h000123);
        @(negedge clk); index_pulse = 1;
        @(negedge clk); index_pulse = 0;
        read24(1, v);
        chk("R12 index loads", v, 24'h000123);
        ctrl(8'h43);
        set_preset(24'h000777);
        @(negedge clk); index_pulse = 1;
        @(negedge clk); index_pulse = 0;
        read24(1, v);
        chk("R12 index disabled", v, 24'h000123);

        // R1: target decoding
        ctrl(8'h38);
        chk("R1 input mode", input_mode, 2'd3);
        ctrl(8'h63);
        chk("R1 index reg", index_cfg, 2'd3);
        ctrl(8'h9F);
        chk("R1 unused target", {input_mode, index_cfg, prescale}, {2'd3, 2'd3, 8'h00});

        // R13: prescaler
        set_preset(24'h12345A);
        ctrl(8'h18);
        chk("R13 prescaler", prescale, 8'h5A);

        // Mode sweep: R7 R8 R9 R10
        ceil = 24'd5;
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 3; s++) begin
                for (int d = 0; d < 2; d++) begin
                    if (m == 1 || m == 3)
                        st = (s == 0) ? 24'd0 : (s == 1) ? 24'd2 : 24'd5;
                    else
                        st = (s == 0) ? 24'd0 : (s == 1) ? 24'hFFFFFC : 24'd3;
                    ctrl(8'h43);
                    ctrl(8'h20 | 8'(m << 1));
                    load_cnt(st);
                    set_preset(ceil);
                    ctrl(8'h04);
                    pulses(d[0], 7);
                    read24(1, v);
                    e = ref_run(m, ceil, st, d[0], 7);
                    case (m)
                        0: begin
                            chk("R7 sweep count", {flags[1] ^ flags[0], v}, {e[25] ^ e[24], e[23:0]});
                            chk("R7 sweep flags", flags[1:0], {e[24], e[25]});
                        end
                        1: begin
                            chk("R8 sweep count", {flags[1] ^ flags[0], v}, {e[25] ^ e[24], e[23:0]});
                            chk("R8 sweep flags", flags[1:0], {e[24], e[25]});
                        end
                        2: begin
                            chk("R9 sweep count", {flags[1] ^ flags[0], v}, {e[25] ^ e[24], e[23:0]});
                            chk("R9 sweep flags", flags[1:0], {e[24], e[25]});
                        end
                        default: begin
                            chk("R10 sweep count", {flags[1] ^ flags[0], v}, {e[25] ^ e[24], e[23:0]});
                            chk("R10 sweep flags", flags[1:0], {e[24], e[25]});
                        end
                    endcase
                end
            end
        end

        // R9: load releases the halt
        ctrl(8'h24);
        load_cnt(24'hFFFFFF);
        pulses(1, 3);
        load_cnt(24'd10);
        pulses(1, 2);
        read24(1, v);
        chk("R9 reload resumes", v, 24'd12);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule